// File: doc/BRIEF.md
# Host-BMC Mailbox Register File

This block is a shared mailbox between a host processor and a board management controller. Each side has its own simple register bus: address, write strobe, write data and a read data port. Sixteen byte-wide data registers can be written and read from either bus. Above them, each side has a private control register at address 16. The host uses its control register to ring a doorbell toward the controller, and the controller answers by filling data registers and writing the response-code register last.

Two interrupt outputs follow two sticky status bits, one per receiving side. The host-bound interrupt fires when the controller writes the response-code register (index 13). It also fires when the controller writes the event byte (index 15) while the host has event notification enabled. The host clears event bits by writing a mask to the event byte. Only the bits inside a parameterised acknowledge mask are affected; the rest can be cleared only by the controller. When both buses write the same data register in one cycle, the controller's write is kept and a one-cycle error flag is raised.

Top module: `host_bmc_mailbox`

## Requirements
- R1: After reset, all sixteen data registers read 0x00, both control registers read 0x00, and `h_irq`, `b_irq` and `bus_clash` are low.
- R2: A write from either bus to address 0..15 stores the byte, except for index 15 from the host (see R7). Both buses then read it back at that address. Writes to addresses 17..31 change nothing, and those addresses read 0x00.
- R3: A host write to address 16 with bit 0 set raises `b_irq` and sets bit 7 of the controller's control register (controller address 16) on the next cycle. Bit 0 is not stored and reads back 0.
- R4: Each status bit (host: bit 7 of host address 16, drives `h_irq`; controller: bit 7 of controller address 16, drives `b_irq`) stays set until its own side writes address 16 with bit 7 set. A write with bit 7 clear leaves the status bit unchanged. When a set and a clear fall in the same cycle, the set wins.
- R5: A controller write to data index 13 sets the host status bit and `h_irq`. A host write to index 13, or a controller write to any data index other than 13 and 15, does not.
- R6: A controller write to data index 15 sets the host status bit only when host control bit 1 (event enable) is 1. Bit 1 is read/write from the host at address 16.
- R7: A host write to index 15 clears the event bits that are 1 both in the written byte and in `ACK_MASK` (default 0x3F). Bits 7:6 are untouched by default. A controller write to index 15 stores the byte as written.
- R8: When both buses write the same data index (0..15) in one cycle, the controller's byte is stored and `bus_clash` is high for exactly the following cycle. Writes to different indices both take effect and do not raise the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 5 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (combinational on `h_addr`) |
| b_wr | input | 1 | Controller write strobe |
| b_addr | input | 5 | Controller register address |
| b_wdata | input | 8 | Controller write data |
| b_rdata | output | 8 | Controller read data (combinational on `b_addr`) |
| h_irq | output | 1 | Interrupt toward the host |
| b_irq | output | 1 | Interrupt toward the controller |
| bus_clash | output | 1 | One-cycle flag for a same-register write collision |

## Verification
Every result is due one rising edge after the write that causes it. This holds for stored bytes, status bits, both interrupts and the clash flag. The reads are combinational, so the bench drives each write at a falling edge and removes it at the next falling edge. It then sets the read address and compares at that point, after the single register stage has taken the write. The clash flag is valid only from that edge to the following one. The bench therefore samples it at that same falling edge, and once more a cycle later to see it drop.

// File: rtl/mbx_pkg.sv
// Package: shared sizing for the host/controller mailbox.
// Assumes byte-wide registers and one control slot right above the data bank.
package mbx_pkg;
    localparam int MBX_NREG      = 16;
    localparam int MBX_DW        = 8;
    localparam int MBX_AW        = 5;
    localparam int MBX_CTRL_ADDR = 16;
    localparam int MBX_RESP_IDX  = 13;
    localparam int MBX_EVT_IDX   = 15;
endpackage

// File: rtl/mbx_status_bit.sv
// Sticky status flag: set by an event, cleared by write-one from the owner.
// Assumes set and clear may coincide; the set wins so no event is lost.
module mbx_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Hold, set or clear the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/mbx_data_bank.sv
// Bank of NREG data bytes written from two buses.
// Assumes write enables are already qualified to data addresses.
// The controller write wins a same-index collision. The event index
// treats host writes as a masked acknowledge, not a store.
module mbx_data_bank #(
    parameter int             NREG     = 16,
    parameter int             DW       = 8,
    parameter int             AW       = 5,
    parameter int             EVT_IDX  = 15,
    parameter logic [DW-1:0]  ACK_MASK = 8'h3F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] regs_o [NREG],
    output logic          clash_o
);
    logic clash_now;

    // Detect both buses hitting the same data index this cycle.
    always_comb clash_now = h_we && b_we && (h_addr == b_addr);

    // Register the collision so the flag lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) clash_o <= 1'b0;
        else        clash_o <= clash_now;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [AW-1:0] IDX = AW'(i);
        logic hsel, bsel;
        assign hsel = h_we && (h_addr == IDX);
        assign bsel = b_we && (b_addr == IDX);

        if (i == EVT_IDX) begin : g_evt
            // Event byte: controller stores, host clears acknowledgeable bits.
            always_ff @(posedge clk) begin
                if (!rst_n)    regs_o[i] <= '0;
                else if (bsel) regs_o[i] <= b_wdata;
                else if (hsel) regs_o[i] <= regs_o[i] & ~(h_wdata & ACK_MASK);
            end
        end else begin : g_plain
            // Plain byte: controller write first, then host write.
            always_ff @(posedge clk) begin
                if (!rst_n)    regs_o[i] <= '0;
                else if (bsel) regs_o[i] <= b_wdata;
                else if (hsel) regs_o[i] <= h_wdata;
            end
        end
    end
endmodule

// File: rtl/host_bmc_mailbox.sv
// Top of the host/controller mailbox: data bank, two control registers,
// two sticky status bits and their interrupts.
// Assumes single-cycle write strobes and combinational reads on each bus.
module host_bmc_mailbox
    import mbx_pkg::*;
#(
    parameter int            NREG      = MBX_NREG,
    parameter int            DW        = MBX_DW,
    parameter int            AW        = MBX_AW,
    parameter int            CTRL_ADDR = MBX_CTRL_ADDR,
    parameter int            RESP_IDX  = MBX_RESP_IDX,
    parameter int            EVT_IDX   = MBX_EVT_IDX,
    parameter logic [DW-1:0] ACK_MASK  = 8'h3F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr,
    input  logic [AW-1:0] h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          h_irq,
    output logic          b_irq,
    output logic          bus_clash
);
    localparam int            IW    = $clog2(NREG);
    localparam logic [AW-1:0] CTRLA = AW'(CTRL_ADDR);
    localparam logic [AW-1:0] RESPA = AW'(RESP_IDX);
    localparam logic [AW-1:0] EVTA  = AW'(EVT_IDX);

    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] evt_q;
    logic          h_data_we, b_data_we, h_ctrl_we, b_ctrl_we;
    logic          h_stat, b_stat, h_evt_en;
    logic          h_set, b_set;

    // Decode writes into data-bank and control-register strobes.
    always_comb begin
        h_data_we = h_wr && (h_addr < AW'(NREG));
        b_data_we = b_wr && (b_addr < AW'(NREG));
        h_ctrl_we = h_wr && (h_addr == CTRLA);
        b_ctrl_we = b_wr && (b_addr == CTRLA);
    end

    mbx_data_bank #(
        .NREG(NREG), .DW(DW), .AW(AW), .EVT_IDX(EVT_IDX), .ACK_MASK(ACK_MASK)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .h_we(h_data_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .b_we(b_data_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .regs_o(regs), .clash_o(bus_clash)
    );

    assign evt_q = regs[EVT_IDX];

    // Host event-notification enable, loaded from host control bit 1.
    always_ff @(posedge clk) begin
        if (!rst_n)         h_evt_en <= 1'b0;
        else if (h_ctrl_we) h_evt_en <= h_wdata[1];
    end

    // Interrupt causes: response commit or enabled event toward host, doorbell toward controller.
    always_comb begin
        h_set = b_wr && ((b_addr == RESPA) || ((b_addr == EVTA) && h_evt_en));
        b_set = h_ctrl_we && h_wdata[0];
    end

    mbx_status_bit u_hstat (
        .clk(clk), .rst_n(rst_n),
        .set_i(h_set), .clr_i(h_ctrl_we && h_wdata[7]), .q_o(h_stat)
    );

    mbx_status_bit u_bstat (
        .clk(clk), .rst_n(rst_n),
        .set_i(b_set), .clr_i(b_ctrl_we && b_wdata[7]), .q_o(b_stat)
    );

    assign h_irq = h_stat;
    assign b_irq = b_stat;

    // Host read mux: data bank, host control view, else zero.
    always_comb begin
        if (h_addr < AW'(NREG))  h_rdata = regs[h_addr[IW-1:0]];
        else if (h_addr == CTRLA) h_rdata = {h_stat, {(DW-3){1'b0}}, h_evt_en, 1'b0};
        else                      h_rdata = '0;
    end

    // Controller read mux: data bank, controller control view, else zero.
    always_comb begin
        if (b_addr < AW'(NREG))  b_rdata = regs[b_addr[IW-1:0]];
        else if (b_addr == CTRLA) b_rdata = {b_stat, {(DW-1){1'b0}}};
        else                      b_rdata = '0;
    end
endmodule

// File: rtl/mbx_checks.sv
// Property checker for the mailbox, attached to the top by bind.
// Assumes it sees the top's ports and its event-byte view evt_q.
module mbx_checks #(
    parameter int            NREG     = 16,
    parameter int            DW       = 8,
    parameter int            AW       = 5,
    parameter int            CTRL     = 16,
    parameter int            RESP     = 13,
    parameter int            EVT      = 15,
    parameter logic [DW-1:0] ACK_MASK = 8'h3F
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_wr,
    input logic [AW-1:0] h_addr,
    input logic [DW-1:0] h_wdata,
    input logic          b_wr,
    input logic [AW-1:0] b_addr,
    input logic [DW-1:0] b_wdata,
    input logic          h_irq,
    input logic          b_irq,
    input logic          bus_clash,
    input logic [DW-1:0] evt_q
);
    // R3: a host doorbell raises the controller interrupt next cycle.
    a_r3_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == AW'(CTRL) && h_wdata[0]) |=> b_irq);

    // R4: host interrupt holds unless the host writes one to bit 7.
    a_r4_host_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (h_irq && !(h_wr && h_addr == AW'(CTRL) && h_wdata[7])) |=> h_irq);

    // R4: controller interrupt holds unless the controller writes one to bit 7.
    a_r4_bmc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (b_irq && !(b_wr && b_addr == AW'(CTRL) && b_wdata[7])) |=> b_irq);

    // R5: a response-code write commits and interrupts the host.
    a_r5_resp_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && b_addr == AW'(RESP)) |=> h_irq);

    // R7: a host acknowledge leaves the non-acknowledgeable bits as they were.
    a_r7_nonack_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_addr == AW'(EVT) && !(b_wr && b_addr == AW'(EVT)))
        |=> ((evt_q & ~ACK_MASK) == ($past(evt_q) & ~ACK_MASK)));

    // R8: a same-index collision raises the clash flag next cycle.
    a_r8_clash_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && b_wr && h_addr == b_addr && h_addr < AW'(NREG)) |=> bus_clash);
endmodule

bind host_bmc_mailbox mbx_checks #(
    .NREG(NREG), .DW(DW), .AW(AW), .CTRL(CTRL_ADDR), .RESP(RESP_IDX),
    .EVT(EVT_IDX), .ACK_MASK(ACK_MASK)
) u_chk (.*);

// File: tb/sim_host_bmc_mailbox.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and compares.
module sim_host_bmc_mailbox;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       h_wr = 1'b0, b_wr = 1'b0;
    logic [4:0] h_addr = '0, b_addr = '0;
    logic [7:0] h_wdata = '0, b_wdata = '0;
    logic [7:0] h_rdata, b_rdata;
    logic       h_irq, b_irq, bus_clash;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        int         sel;   // 0 host read, 1 ctrl read, 2 h_irq, 3 b_irq, 4 bus_clash
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_bmc_mailbox u0 (
        .clk(clk), .rst_n(rst_n),
        .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .h_irq(h_irq), .b_irq(b_irq), .bus_clash(bus_clash)
    );

    // Monitor: pop expected items and compare against the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                case (it.sel)
                    0:       act = h_rdata;
                    1:       act = b_rdata;
                    2:       act = {7'b0, h_irq};
                    3:       act = {7'b0, b_irq};
                    default: act = {7'b0, bus_clash};
                endcase
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic push(input string req, input int sel, input logic [7:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic exp_h(input string req, input logic [4:0] a, input logic [7:0] v);
        h_addr = a; #1; push(req, 0, v);
    endtask

    task automatic exp_b(input string req, input logic [4:0] a, input logic [7:0] v);
        b_addr = a; #1; push(req, 1, v);
    endtask

    task automatic both(input bit hw, input logic [4:0] ha, input logic [7:0] hd,
                        input bit bw, input logic [4:0] ba, input logic [7:0] bd);
        @(negedge clk);
        h_wr = hw; h_addr = ha; h_wdata = hd;
        b_wr = bw; b_addr = ba; b_wdata = bd;
        @(negedge clk);
        h_wr = 1'b0; b_wr = 1'b0;
    endtask

    task automatic hwr(input logic [4:0] a, input logic [7:0] d);
        both(1'b1, a, d, 1'b0, 5'd0, 8'h00);
    endtask

    task automatic bwr(input logic [4:0] a, input logic [7:0] d);
        both(1'b0, 5'd0, 8'h00, 1'b1, a, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; h_wr = 1'b0; b_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    // Driver: stimulus with expected results pushed to the scoreboard.
    initial begin
        do_reset();
        // R1: reset state
        exp_h("R1", 5'd0, 8'h00);
        exp_h("R1", 5'd15, 8'h00);
        exp_h("R1", 5'd16, 8'h00);
        exp_b("R1", 5'd16, 8'h00);
        push("R1", 2, 8'h00); push("R1", 3, 8'h00); push("R1", 4, 8'h00);

        // R2: stores from both sides, out-of-range ignored
        hwr(5'd3, 8'hA5);
        exp_b("R2", 5'd3, 8'hA5);
        bwr(5'd9, 8'h3C);
        exp_h("R2", 5'd9, 8'h3C);
        push("R5", 2, 8'h00);
        hwr(5'd20, 8'h77);
        exp_h("R2", 5'd20, 8'h00);
        exp_h("R2", 5'd4, 8'h00);
        exp_b("R2", 5'd3, 8'hA5);

        // R3: doorbell
        hwr(5'd16, 8'h01);
        push("R3", 3, 8'h01);
        exp_b("R3", 5'd16, 8'h80);
        exp_h("R3", 5'd16, 8'h00);

        // R4: clear needs bit 7 from the owner
        bwr(5'd16, 8'h00);
        push("R4", 3, 8'h01);
        bwr(5'd16, 8'h80);
        push("R4", 3, 8'h00);
        exp_b("R4", 5'd16, 8'h00);

        // R5: response commit
        hwr(5'd13, 8'h11);
        push("R5", 2, 8'h00);
        bwr(5'd13, 8'h00);
        push("R5", 2, 8'h01);
        exp_h("R5", 5'd16, 8'h80);
        hwr(5'd16, 8'h80);
        push("R4", 2, 8'h00);
        exp_h("R5", 5'd13, 8'h00);

        // R6: event notification gated by enable
        bwr(5'd15, 8'hC3);
        push("R6", 2, 8'h00);
        exp_h("R6", 5'd15, 8'hC3);
        hwr(5'd16, 8'h02);
        exp_h("R6", 5'd16, 8'h02);
        bwr(5'd15, 8'hC7);
        push("R6", 2, 8'h01);
        exp_h("R6", 5'd16, 8'h82);
        hwr(5'd16, 8'h82);
        exp_h("R6", 5'd16, 8'h02);
        push("R6", 2, 8'h00);

        // R7: masked acknowledge
        hwr(5'd15, 8'hFF);
        exp_b("R7", 5'd15, 8'hC0);
        bwr(5'd15, 8'h0F);
        exp_b("R7", 5'd15, 8'h0F);
        hwr(5'd15, 8'h05);
        exp_b("R7", 5'd15, 8'h0A);
        hwr(5'd16, 8'h82);

        // R8: collisions
        both(1'b1, 5'd7, 8'h11, 1'b1, 5'd7, 8'h22);
        push("R8", 4, 8'h01);
        exp_h("R8", 5'd7, 8'h22);
        @(negedge clk);
        push("R8", 4, 8'h00);
        both(1'b1, 5'd7, 8'h33, 1'b1, 5'd8, 8'h44);
        push("R8", 4, 8'h00);
        exp_h("R8", 5'd7, 8'h33);
        exp_h("R8", 5'd8, 8'h44);

        // R4: set wins over simultaneous clear, both sides
        both(1'b1, 5'd16, 8'h01, 1'b1, 5'd16, 8'h80);
        push("R4", 3, 8'h01);
        push("R4", 4, 8'h00);
        bwr(5'd16, 8'h80);
        push("R4", 3, 8'h00);
        both(1'b1, 5'd16, 8'h82, 1'b1, 5'd13, 8'h00);
        push("R4", 2, 8'h01);

        // R1: reset mid-run clears everything
        do_reset();
        exp_h("R1", 5'd7, 8'h00);
        exp_h("R1", 5'd16, 8'h00);
        push("R1", 2, 8'h00);

        done = 1'b1;
        finish_run();
    end
endmodule